// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This unit watches the processor's access stream and flags accesses that fall on one of four programmable breakpoints. Each breakpoint has an address register and a configuration slice inside a shared control word. The slice holds a local and a global enable, a 2-bit access-kind selector and a 2-bit length selector. Every accepted access is compared against all four breakpoints in parallel. A comparator that matches sets its sticky flag in the status word. A debug-exception request pulses one cycle later when at least one matching breakpoint is enabled.

Software reaches the six registers through a simple register port. Only the most privileged ring may use it; any other ring is refused. The access stream is a valid/ready interface. The unit never applies back-pressure once reset is over: `acc_ready` is low during reset and in the first cycle after it, then stays high, and an access counts only in a cycle where both `acc_valid` and `acc_ready` are high. A resume input lets the core re-execute a faulting instruction without re-triggering an instruction breakpoint. A debug-extension input, taken from bit 3 of a separate feature control register, enables a fourth access kind that watches I/O-port accesses.

Top module: `bpm_top`

## Requirements
- R1: Reset values and addressing. While `rst_n` is low, `dbg_req` and `acc_ready` are 0. Register addresses are: 0 to 3 are breakpoint address registers 0 to 3, 6 is the status word, and 7 is the control word. Addresses 4 and 5 read 0. After reset the breakpoint registers read 0, the control word reads 0x0000_0400, the status word reads 0xFFFF_0FF0 and `dbg_hits` is 0.
- R2: A register access is granted only when `reg_priv` is 0. Otherwise a write is ignored, `reg_rdata` is 0 and `reg_fault` is 1 in the same cycle. A granted access leaves `reg_fault` at 0.
- R3: Control word layout:
  - bit 2n is the local enable and bit 2n+1 the global enable of breakpoint n;
  - bits 8, 9 and 13 are plain storage;
  - bit 10 always reads 1, and bits 11, 12, 14 and 15 always read 0;
  - bits 16+4n..17+4n hold the access kind of breakpoint n, and bits 18+4n..19+4n its length.
  
  Writing all ones therefore reads back 0xFFFF_27FF.
- R4: In the status word, bits 0-3 (breakpoint flags) and bits 13-15 (detect, single-step and task-switch flags) are writable. Bits 4-11 and 16-31 always read 1, and bit 12 always reads 0. `dbg_hits` shows bits 0-3.
- R5: Breakpoint length encodings:
  - 00 covers 1 byte at the register address;
  - 01 covers 2 bytes, with address bit 0 cleared;
  - 11 covers 4 bytes, with address bits 1:0 cleared.
  
  The access size `acc_size` is 00 = 1 byte, 01 = 2 bytes, and 10 or 11 = 4 bytes, starting at `acc_addr`. A breakpoint matches when any byte of the access lies in its range.
- R6: A breakpoint with length 10 never matches.
- R7: `acc_kind` is encoded as 00 = fetch, 01 = data read, 10 = data write, 11 = I/O. Breakpoint kind 00 matches fetches only, kind 01 matches data writes only, and kind 11 matches data reads and data writes but never fetches.
- R8: Breakpoint kind 10 matches I/O accesses when `dbg_ext` is 1 and matches nothing when `dbg_ext` is 0.
- R9: Status flags 0-3 are sticky. A match sets flag n even when breakpoint n is disabled, and only a granted write clears a flag. When a match and a status write fall in the same cycle, the flag ends up set.
- R10: `dbg_req` is high for exactly the cycle after an accepted access in which some matching breakpoint has its local or global enable set. It is low in every other cycle.
- R11: When `acc_resume` is 1 on an accepted fetch, that fetch raises no request, but its status flags are still set. `acc_resume` has no effect on data accesses.
- R12: `acc_ready` rises in the second cycle after reset ends and stays high. An access presented while `acc_valid` is 0, or while `rst_n` is low, changes neither the status word nor `dbg_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present |
| acc_ready | output | 1 | Unit accepts accesses |
| acc_addr | input | AW | Access start address |
| acc_kind | input | 2 | Access kind (fetch, read, write, I/O) |
| acc_size | input | 2 | Access size code |
| acc_resume | input | 1 | Suppress fetch requests for this access |
| dbg_ext | input | 1 | Debug-extension enable |
| reg_en | input | 1 | Register port access strobe |
| reg_we | input | 1 | Register port write |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_priv | input | 2 | Privilege ring of the requester (0 = highest) |
| reg_rdata | output | 32 | Register read data (combinational) |
| reg_fault | output | 1 | Access refused for privilege |
| dbg_req | output | 1 | Debug-exception request pulse |
| dbg_hits | output | 4 | Sticky per-breakpoint match flags |

## Verification
The bench sweeps every combination of breakpoint length, breakpoint kind, access kind, access size and debug-extension setting, with access addresses sliding across an unaligned breakpoint address. This exposes a design that fails to clear the low address bits, tests only the start byte of a wide access, or lets length 10 or kind 10 match when they should not. Directed cases target stickiness: a disabled breakpoint must still set its flag, and a match that coincides with a clearing write must win; a design that got these wrong would lose hits. Further cases cover a resume that must hide a fetch request but keep its flag, the reserved status and control bits, and refused accesses from lower rings, which a careless design would let modify registers or leak data.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  localparam int unsigned NUM_BP  = 4;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned CFG_LSB = 16;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_IO    = 2'b11
  } acc_kind_e;

  localparam logic [2:0] RA_STAT = 3'd6;
  localparam logic [2:0] RA_CTRL = 3'd7;

  localparam logic [REG_W-1:0] CTRL_WMASK = 32'hFFFF_23FF;
  localparam logic [REG_W-1:0] CTRL_FIXED = 32'h0000_0400;
endpackage

// File: rtl/bpm_cmp.sv
module bpm_cmp
  import bpm_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] bp_addr,
  input  logic [1:0]    bp_len,
  input  logic [1:0]    bp_kind,
  input  logic          ext_en,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_kind,
  input  logic [1:0]    acc_size,
  output logic          hit
);
  logic [1:0]  b_extra;
  logic [1:0]  a_extra;
  logic        len_ok;
  logic        kind_ok;
  logic [AW:0] b_lo, b_hi, a_lo, a_hi;

  always_comb begin
    len_ok  = 1'b1;
    b_extra = 2'd0;
    unique case (bp_len)
      2'b00: b_extra = 2'd0;
      2'b01: b_extra = 2'd1;
      2'b11: b_extra = 2'd3;
      default: len_ok = 1'b0;
    endcase
    unique case (acc_size)
      2'b00: a_extra = 2'd0;
      2'b01: a_extra = 2'd1;
      default: a_extra = 2'd3;
    endcase
  end

  always_comb begin
    unique case (bp_kind)
      2'b00: kind_ok = (acc_kind == ACC_FETCH);
      2'b01: kind_ok = (acc_kind == ACC_WRITE);
      2'b11: kind_ok = (acc_kind == ACC_READ) || (acc_kind == ACC_WRITE);
      default: kind_ok = ext_en && (acc_kind == ACC_IO);
    endcase
  end

  always_comb begin
    b_lo = {1'b0, bp_addr & ~{{(AW-2){1'b0}}, b_extra}};
    b_hi = b_lo + {{(AW-1){1'b0}}, b_extra};
    a_lo = {1'b0, acc_addr};
    a_hi = a_lo + {{(AW-1){1'b0}}, a_extra};
  end

  assign hit = len_ok && kind_ok && (a_lo <= b_hi) && (b_lo <= a_hi);
endmodule

// File: rtl/bpm_regs.sv
module bpm_regs
  import bpm_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_en,
  input  logic                      reg_we,
  input  logic [2:0]                reg_addr,
  input  logic [REG_W-1:0]          reg_wdata,
  input  logic [1:0]                reg_priv,
  output logic [REG_W-1:0]          reg_rdata,
  output logic                      reg_fault,
  input  logic [NUM_BP-1:0]         hit_set,
  output logic [NUM_BP*AW-1:0]      bp_addr_flat,
  output logic [NUM_BP-1:0]         bp_en,
  output logic [NUM_BP*FIELD_W-1:0] bp_cfg,
  output logic [NUM_BP-1:0]         hits_q
);
  localparam int unsigned CFG_W = NUM_BP * FIELD_W;

  logic             grant;
  logic             wr_go;
  logic [AW-1:0]    bp_q [NUM_BP];
  logic [REG_W-1:0] ctrl_q;
  logic [NUM_BP-1:0] flag_q;
  logic [2:0]       misc_q;

  assign grant     = reg_en && (reg_priv == 2'd0);
  assign reg_fault = reg_en && !grant;
  assign wr_go     = grant && reg_we;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
    always_ff @(posedge clk) begin
      if (!rst_n)
        bp_q[i] <= '0;
      else if (wr_go && reg_addr == 3'(i))
        bp_q[i] <= reg_wdata[AW-1:0];
    end
    assign bp_addr_flat[i*AW +: AW] = bp_q[i];
    assign bp_en[i] = ctrl_q[2*i] | ctrl_q[2*i+1];
  end

  assign bp_cfg = ctrl_q[CFG_LSB +: CFG_W];

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (wr_go && reg_addr == RA_CTRL)
      ctrl_q <= reg_wdata & CTRL_WMASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      misc_q <= '0;
    end else begin
      if (wr_go && reg_addr == RA_STAT) begin
        flag_q <= reg_wdata[NUM_BP-1:0] | hit_set;
        misc_q <= reg_wdata[15:13];
      end else begin
        flag_q <= flag_q | hit_set;
      end
    end
  end

  assign hits_q = flag_q;

  always_comb begin
    reg_rdata = '0;
    if (grant) begin
      if (!reg_addr[2])
        reg_rdata = REG_W'(bp_q[reg_addr[1:0]]);
      else if (reg_addr == RA_STAT)
        reg_rdata = {16'hFFFF, misc_q, 1'b0, 8'hFF, flag_q};
      else if (reg_addr == RA_CTRL)
        reg_rdata = ctrl_q | CTRL_FIXED;
    end
  end
endmodule

// File: rtl/bpm_top.sv
module bpm_top
  import bpm_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [AW-1:0]     acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic [1:0]        acc_size,
  input  logic              acc_resume,
  input  logic              dbg_ext,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [1:0]        reg_priv,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              reg_fault,
  output logic              dbg_req,
  output logic [NUM_BP-1:0] dbg_hits
);
  logic                      rdy_q;
  logic                      accept;
  logic [NUM_BP-1:0]         raw_hit;
  logic [NUM_BP-1:0]         hit_set;
  logic [NUM_BP*AW-1:0]      bp_addr_flat;
  logic [NUM_BP-1:0]         bp_en;
  logic [NUM_BP*FIELD_W-1:0] bp_cfg;
  logic                      req_d;
  logic                      req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign acc_ready = rdy_q;
  assign accept    = acc_valid && rdy_q;

  bpm_regs #(.AW(AW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_en       (reg_en),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_priv     (reg_priv),
    .reg_rdata    (reg_rdata),
    .reg_fault    (reg_fault),
    .hit_set      (hit_set),
    .bp_addr_flat (bp_addr_flat),
    .bp_en        (bp_en),
    .bp_cfg       (bp_cfg),
    .hits_q       (dbg_hits)
  );

  for (genvar n = 0; n < NUM_BP; n++) begin : g_cmp
    bpm_cmp #(.AW(AW)) u_cmp (
      .bp_addr  (bp_addr_flat[n*AW +: AW]),
      .bp_len   (bp_cfg[n*FIELD_W+2 +: 2]),
      .bp_kind  (bp_cfg[n*FIELD_W +: 2]),
      .ext_en   (dbg_ext),
      .acc_addr (acc_addr),
      .acc_kind (acc_kind),
      .acc_size (acc_size),
      .hit      (raw_hit[n])
    );
  end

  assign hit_set = accept ? raw_hit : '0;
  assign req_d   = accept && |(raw_hit & bp_en)
                   && !(acc_resume && acc_kind == ACC_FETCH);

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign dbg_req = req_q;
endmodule

// File: rtl/bpm_chk.sv
module bpm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_ready,
  input logic [1:0]  acc_kind,
  input logic        acc_resume,
  input logic        reg_en,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [1:0]  reg_priv,
  input logic [31:0] reg_rdata,
  input logic        reg_fault,
  input logic        dbg_req,
  input logic [3:0]  dbg_hits
);
  a_r12_ready_stays: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |=> acc_ready);

  a_r10_req_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req |-> $past(acc_valid && acc_ready));

  a_r11_resume_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid && acc_ready && acc_resume && acc_kind == 2'b00) |-> !dbg_req);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_en && reg_we && reg_priv == 2'd0 && reg_addr == 3'd6)
      |-> ((dbg_hits & $past(dbg_hits)) == $past(dbg_hits)));

  a_r2_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_priv != 2'd0) |-> (reg_rdata == 32'd0 && reg_fault));

  a_r4_stat_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_priv == 2'd0 && reg_addr == 3'd6)
      |-> ((reg_rdata & 32'hFFFF_1FF0) == 32'hFFFF_0FF0));

  a_r3_ctrl_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_priv == 2'd0 && reg_addr == 3'd7)
      |-> ((reg_rdata & 32'h0000_DC00) == 32'h0000_0400));
endmodule

bind bpm_top bpm_chk u_chk (.*);

// File: tb/sim_bpm_top.sv
module sim_bpm_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic [1:0]  acc_size = '0;
  logic        acc_resume = 1'b0;
  logic        dbg_ext = 1'b0;
  logic        reg_en = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  reg_priv = '0;
  logic [31:0] reg_rdata;
  logic        reg_fault;
  logic        dbg_req;
  logic [3:0]  dbg_hits;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bpm_top u0 (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [1:0] p);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d; reg_priv = p;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] p,
                    output logic [31:0] d, output logic f);
    reg_en = 1; reg_we = 0; reg_addr = a; reg_priv = p;
    #1;
    d = reg_rdata; f = reg_fault;
    reg_en = 0;
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] k, input logic [1:0] s, input logic rf);
    @(negedge clk);
    acc_valid = 1; acc_addr = a; acc_kind = k; acc_size = s; acc_resume = rf;
    @(negedge clk);
    acc_valid = 0; acc_resume = 0;
  endtask

  function automatic bit exp_hit(input int len, input int bk, input bit de,
                                 input longint bpa, input int ak, input longint a, input int sz);
    longint bl, bs, al;
    bit kind_ok;
    if (len == 2) return 0;
    bl = (len == 0) ? 1 : (len == 1) ? 2 : 4;
    bs = bpa - (bpa % bl);
    al = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    case (bk)
      0: kind_ok = (ak == 0);
      1: kind_ok = (ak == 2);
      3: kind_ok = (ak == 1) || (ak == 2);
      default: kind_ok = de && (ak == 3);
    endcase
    return kind_ok && (a < bs + bl) && (bs < a + al);
  endfunction

  initial begin
    #(8 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic f;
    bit e;
    // R1 / R12: reset state, access ignored while in reset
    repeat (2) @(negedge clk);
    acc_valid = 1; acc_addr = 32'h0; acc_kind = 2'b00;
    @(negedge clk);
    acc_valid = 0;
    chk(acc_ready == 0, "R1 ready in reset", acc_ready, 0);
    chk(dbg_req == 0, "R1 req in reset", dbg_req, 0);
    rd(3'd7, 2'd0, d, f); chk(d == 32'h0000_0400, "R1 ctrl reset", d, 32'h400);
    rd(3'd6, 2'd0, d, f); chk(d == 32'hFFFF_0FF0, "R1 status reset", d, 32'hFFFF0FF0);
    rd(3'd2, 2'd0, d, f); chk(d == 0, "R1 bp2 reset", d, 0);
    rd(3'd5, 2'd0, d, f); chk(d == 0, "R1 addr5 reads 0", d, 0);
    chk(dbg_hits == 0, "R12 no hits from reset access", dbg_hits, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    chk(acc_ready == 1, "R12 ready after reset", acc_ready, 1);

    // R2 privilege
    wr(3'd0, 32'h1234_5678, 2'd0);
    wr(3'd0, 32'hDEAD_BEEF, 2'd3);
    @(negedge clk);
    rd(3'd0, 2'd1, d, f);
    chk(d == 0 && f == 1, "R2 refused read", {f, d}, 64'h1_0000_0000);
    rd(3'd0, 2'd0, d, f);
    chk(d == 32'h1234_5678 && f == 0, "R2 refused write ignored", d, 32'h12345678);

    // R3 control layout
    wr(3'd7, 32'hFFFF_FFFF, 2'd0);
    @(negedge clk); rd(3'd7, 2'd0, d, f);
    chk(d == 32'hFFFF_27FF, "R3 ctrl all ones", d, 32'hFFFF27FF);
    wr(3'd7, 32'h0, 2'd0);
    @(negedge clk); rd(3'd7, 2'd0, d, f);
    chk(d == 32'h0000_0400, "R3 ctrl zero", d, 32'h400);

    // R4 status layout
    wr(3'd6, 32'hFFFF_FFFF, 2'd0);
    @(negedge clk); rd(3'd6, 2'd0, d, f);
    chk(d == 32'hFFFF_EFFF, "R4 status all ones", d, 32'hFFFFEFFF);
    chk(dbg_hits == 4'hF, "R4 hits pins", dbg_hits, 4'hF);
    wr(3'd6, 32'h0, 2'd0);
    @(negedge clk); rd(3'd6, 2'd0, d, f);
    chk(d == 32'hFFFF_0FF0, "R4 status zero", d, 32'hFFFF0FF0);

    // R5 R6 R7 R8 R10 sweep on breakpoint 0
    wr(3'd0, 32'h0000_1003, 2'd0);
    for (int de = 0; de < 2; de++) begin
      dbg_ext = de[0];
      for (int len = 0; len < 4; len++) begin
        for (int bk = 0; bk < 4; bk++) begin
          wr(3'd7, (32'(bk) << 16) | (32'(len) << 18) | ((len % 2 == 0) ? 32'h1 : 32'h2), 2'd0);
          for (int ak = 0; ak < 4; ak++)
            for (int sz = 0; sz < 3; sz++)
              for (int k = 0; k < 9; k++) begin
                wr(3'd6, 32'h0, 2'd0);
                acc(32'h0FFE + 32'(k), 2'(ak), 2'(sz), 1'b0);
                e = exp_hit(len, bk, de[0], 64'h1003, ak, 64'h0FFE + k, sz);
                chk(dbg_req == e, "R5 R6 R7 R8 R10 request", dbg_req, e);
                chk(dbg_hits == {3'b0, e}, "R5 R6 R7 R8 R9 flag", dbg_hits, e);
                @(negedge clk);
                chk(dbg_req == 0, "R10 single pulse", dbg_req, 0);
              end
        end
      end
    end
    dbg_ext = 0;

    // R9 disabled breakpoint still sets its flag; sticky; hit beats clear
    wr(3'd6, 32'h0, 2'd0);
    wr(3'd7, 32'h0010_0000, 2'd0);
    acc(32'h0000_1003, 2'b00, 2'b00, 1'b0);
    chk(dbg_req == 0, "R9 disabled no request", dbg_req, 0);
    chk(dbg_hits == 4'h1, "R9 disabled sets flag", dbg_hits, 1);
    acc(32'h0000_2000, 2'b10, 2'b00, 1'b0);
    chk(dbg_hits == 4'h1, "R9 flag sticky", dbg_hits, 1);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = 3'd6; reg_wdata = 32'h0; reg_priv = 0;
    acc_valid = 1; acc_addr = 32'h0000_1003; acc_kind = 2'b00; acc_size = 0;
    @(negedge clk);
    reg_en = 0; reg_we = 0; acc_valid = 0;
    chk(dbg_hits == 4'h1, "R9 hit wins over clear", dbg_hits, 1);
    wr(3'd6, 32'h0, 2'd0);
    chk(dbg_hits == 4'h0, "R9 cleared by write", dbg_hits, 0);
    // R12 access with valid low has no effect
    @(negedge clk);
    acc_addr = 32'h0000_1003; acc_kind = 2'b00;
    @(negedge clk);
    chk(dbg_hits == 0 && dbg_req == 0, "R12 valid low ignored", dbg_hits, 0);

    // R11 resume
    wr(3'd7, 32'h0000_0001, 2'd0);
    acc(32'h0000_1003, 2'b00, 2'b00, 1'b1);
    chk(dbg_req == 0, "R11 resume hides fetch request", dbg_req, 0);
    chk(dbg_hits == 4'h1, "R11 resume keeps flag", dbg_hits, 1);
    acc(32'h0000_1003, 2'b00, 2'b00, 1'b0);
    chk(dbg_req == 1, "R11 fetch request without resume", dbg_req, 1);
    wr(3'd7, 32'h0001_0001, 2'd0);
    acc(32'h0000_1003, 2'b10, 2'b00, 1'b1);
    chk(dbg_req == 1, "R11 resume no effect on write", dbg_req, 1);

    // R3 R10 breakpoints 1..3 with global enable, write kind, 4 bytes
    for (int n = 1; n < 4; n++) begin
      wr(3'd6, 32'h0, 2'd0);
      wr(3'(n), 32'h0000_4000 + 32'(n) * 32'h100, 2'd0);
      wr(3'd7, (32'h1 << (2 * n + 1)) | (32'hD << (16 + 4 * n)), 2'd0);
      acc(32'h0000_4003 + 32'(n) * 32'h100, 2'b10, 2'b00, 1'b0);
      chk(dbg_req == 1, "R3 R10 upper breakpoint request", dbg_req, 1);
      chk(dbg_hits == 4'(1 << n), "R3 upper breakpoint flag", dbg_hits, 1 << n);
      acc(32'h0000_4004 + 32'(n) * 32'h100, 2'b10, 2'b00, 1'b0);
      chk(dbg_req == 0, "R5 beyond 4-byte range", dbg_req, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule